// File: doc/BRIEF.md
# Asynchronous 16x4 Latch RAM

This block is a small static memory with no clock. It holds sixteen words of four bits, and each bit is a transparent latch. A four-bit address picks one word. The memory has separate write-data and read-data buses. Two active-low controls set what it does: a select line and a combined read/write line, where high means read and low means write. When the memory is not selected, the read bus floats and nothing can be written. When it is selected, the read bus is always driven.

By default the read bus carries the bitwise complement of the addressed word. A parameter selects a non-inverting variant, which is the same in every other way. A write is level-sensitive. While the write line is low, the addressed word follows the write-data bus. The word keeps the value that was present when the write line returned high.

The intended use is as a scratch register file driven by a controller that settles the address before it pulses the write line. With the write line held low, stepping through the addresses fills every visited word with the current input. This gives a quick way to clear the whole array.

Top module: `async_latch_ram`

## Requirements
- R1: The array holds 16 independent 4-bit words, and a 4-bit address `addr` selects exactly one of them.
- R2: With `cs_n`=0 and `rd_wr_n`=1, `dout` drives the bitwise complement of the addressed word (with the default `INVERT_OUT`=1). When `addr` changes, `dout` changes to the newly addressed word.
- R3: With `cs_n`=1, every bit of `dout` is high-impedance. No word changes, whatever the values of `rd_wr_n`, `addr` and `din`.
- R4: With `cs_n`=0 and `rd_wr_n`=0, the addressed word follows `din` continuously. `dout` stays driven and shows the complement of `din`.
- R5: The word keeps the `din` value that is present when `rd_wr_n` rises. Later changes on `din` have no effect on it.
- R6: A write changes only the addressed word, as long as `addr` changes only while `rd_wr_n` is high.
- R7: If `rd_wr_n` stays low while `addr` steps through all 16 values, the current `din` is written into every word. With `din`=0000 the whole array is cleared.
- R8: With `INVERT_OUT`=0, `dout` carries the stored word without inversion. In every other respect this variant behaves the same as the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cs_n | input | 1 | Select, active low. When high, the read bus floats and writes are blocked. |
| rd_wr_n | input | 1 | High to read, low to write the addressed word. |
| addr | input | 4 | Word address. |
| din | input | 4 | Write data. |
| dout | output | 4 | Read data: inverted or true depending on the parameter, and high-impedance when the memory is not selected. |

## Verification
The assertions assume the inputs are at known logic levels. They also assume that the address does not move while the write line is low, except in the deliberate clearing sweep, where every word that is touched is meant to receive the input anyway. The bench changes the address only with the write line high. The only exception is the sweep test. Power-up contents are undefined, so the bench writes every word before it reads it back. To tell a floating bus apart from a driven one, the bench pulls the bus up and then arranges for the driven value to be all zeros.

// File: rtl/lram_pkg.sv
// Package: shared sizing for the asynchronous latch RAM.
// Assumes: nothing; holds constants only.
package lram_pkg;
    localparam int unsigned LRAM_ADDR_W = 4;
    localparam int unsigned LRAM_DATA_W = 4;
    localparam bit          LRAM_INVERT = 1'b1;
endpackage

// File: rtl/lram_decode.sv
// Module: lram_decode
// Turns the address into one-hot latch enables, but only while the memory is
// selected and the write line is low.
// Assumes: the address is stable while the write line is low (except in a
// deliberate sweep).
module lram_decode #(
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  wen
);

    // Purpose: open at most one word's latches during a write.
    always_comb begin
        wen = '0;
        if (!sel_n && !wr_n) begin
            wen[addr] = 1'b1;
        end
    end

    // Purpose: R1 check, no two words are ever open at the same time.
    always_comb begin
        if (!$isunknown(wen)) begin
            p_one_word_open_r1: assert ($onehot0(wen))
                else $error("R1: more than one word enabled");
        end
    end

endmodule

// File: rtl/lram_word.sv
// Module: lram_word
// One storage word built from level-sensitive latches. While the enable is
// high the word copies its input; when the enable is low it holds.
// Assumes: the enable is free of glitches (the decoder is gated by the write line).
module lram_word #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              le,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // Purpose: transparent while enabled, hold otherwise.
    always_latch begin
        if (le) begin
            q = d;
        end
    end

endmodule

// File: rtl/lram_outstage.sv
// Module: lram_outstage
// Selects the addressed word, applies the output polarity, and reports when
// the bus should be driven.
// Assumes: the words are packed with word 0 in the lowest slice.
module lram_outstage #(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 4,
    parameter bit          INVERT_OUT = 1'b1,
    localparam int unsigned DEPTH     = 1 << ADDR_W
) (
    input  logic                         sel_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DEPTH-1:0][DATA_W-1:0] words,
    output logic                         drive_en,
    output logic [DATA_W-1:0]            drive_val
);

    logic [DATA_W-1:0] picked;

    // Purpose: read mux on the addressed word.
    always_comb begin
        picked = words[addr];
    end

    // Purpose: the bus is driven whenever the memory is selected, in reads and writes alike.
    always_comb begin
        drive_en = !sel_n;
    end

    // Purpose: choose the polarity variant at elaboration.
    generate
        if (INVERT_OUT) begin : g_inv
            always_comb drive_val = ~picked;
        end else begin : g_true
            always_comb drive_val = picked;
        end
    endgenerate

endmodule

// File: rtl/async_latch_ram.sv
// Module: async_latch_ram
// A clockless memory of 2**ADDR_W words of DATA_W bits. Writes are
// level-sensitive through transparent latches. The read bus is inverted by
// default and floats when the memory is not selected.
// Assumes: the address changes only while rd_wr_n is high, unless a write
// sweep is intended. Power-up contents are undefined.
module async_latch_ram #(
    parameter int unsigned ADDR_W     = lram_pkg::LRAM_ADDR_W,
    parameter int unsigned DATA_W     = lram_pkg::LRAM_DATA_W,
    parameter bit          INVERT_OUT = lram_pkg::LRAM_INVERT
) (
    input  logic              cs_n,
    input  logic              rd_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0]             wen;
    logic [DEPTH-1:0][DATA_W-1:0] words;
    logic                         drive_en;
    logic [DATA_W-1:0]            drive_val;

    lram_decode #(.ADDR_W(ADDR_W)) decode_i (
        .sel_n (cs_n),
        .wr_n  (rd_wr_n),
        .addr  (addr),
        .wen   (wen)
    );

    // Purpose: one latch word per address.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            lram_word #(.DATA_W(DATA_W)) word_i (
                .le (wen[g]),
                .d  (din),
                .q  (words[g])
            );
        end
    endgenerate

    lram_outstage #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .INVERT_OUT (INVERT_OUT)
    ) out_i (
        .sel_n     (cs_n),
        .addr      (addr),
        .words     (words),
        .drive_en  (drive_en),
        .drive_val (drive_val)
    );

    // Purpose: three-state driver on the read bus.
    assign dout = drive_en ? drive_val : 'z;

    // Purpose: relate the bus state and the latch contents to the controls.
    always_comb begin
        if (!$isunknown({cs_n, rd_wr_n, addr, din})) begin
            if (cs_n) begin
                p_float_when_idle_r3: assert (!drive_en)
                    else $error("R3: bus driven while deselected");
            end
            if (!cs_n && rd_wr_n && !$isunknown(words[addr])) begin
                p_read_polarity_r2: assert (drive_val ==
                        (INVERT_OUT ? ~words[addr] : words[addr]))
                    else $error("R2: read value does not match stored word");
            end
            if (!cs_n && !rd_wr_n) begin
                p_write_transparent_r4: assert (words[addr] == din && drive_en)
                    else $error("R4: open word not following input");
            end
        end
    end

endmodule

// File: tb/async_latch_ram_tb_top.sv
module async_latch_ram_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_wr_n = 1'b1;
    logic [3:0] addr = '0;
    logic [3:0] din = '0;
    wire  [3:0] dout;
    wire  [3:0] dout_t;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Weak pull-ups so that a floating bus reads as all ones.
    generate
        for (genvar i = 0; i < 4; i++) begin : g_pull
            pullup (dout[i]);
            pullup (dout_t[i]);
        end
    endgenerate

    async_latch_ram dut_i (
        .cs_n(cs_n), .rd_wr_n(rd_wr_n), .addr(addr), .din(din), .dout(dout)
    );

    async_latch_ram #(.INVERT_OUT(1'b0)) dut_true_i (
        .cs_n(cs_n), .rd_wr_n(rd_wr_n), .addr(addr), .din(din), .dout(dout_t)
    );

    task automatic step();
        #(CLK_PERIOD);
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Write one word, moving the address only while the write line is high.
    task automatic write_word(input logic [3:0] a, input logic [3:0] d);
        rd_wr_n = 1'b1; cs_n = 1'b0; addr = a; din = d; step();
        rd_wr_n = 1'b0; step();
        rd_wr_n = 1'b1; step();
    endtask

    task automatic read_word(input logic [3:0] a, output logic [3:0] inv, output logic [3:0] tru);
        cs_n = 1'b0; rd_wr_n = 1'b1; addr = a; step();
        inv = dout; tru = dout_t;
    endtask

    // R3: the bus floats before any access.
    task automatic t_idle_float();
        cs_n = 1'b1; step();
        check("R3 idle float", dout, 4'b1111);
    endtask

    // R1, R2, R6, R8: distinct pattern per word, read back in both variants.
    task automatic t_fill_readback();
        logic [3:0] v, t;
        for (int a = 0; a < 16; a++) write_word(4'(a), 4'(a ^ 4'h5));
        for (int a = 15; a >= 0; a--) begin
            read_word(4'(a), v, t);
            check("R1/R2 inverted read", v, ~4'(a ^ 4'h5));
            check("R8 true read", t, 4'(a ^ 4'h5));
        end
        write_word(4'd7, 4'h0);
        read_word(4'd6, v, t);
        check("R6 neighbour kept", v, ~4'(6 ^ 5));
        read_word(4'd8, v, t);
        check("R6 neighbour kept", v, ~4'(8 ^ 5));
        read_word(4'd7, v, t);
        check("R6 target written", v, 4'hF);
    endtask

    // R4, R5: transparent during write, hold the value present at the rising edge.
    task automatic t_transparent();
        logic [3:0] v, t;
        cs_n = 1'b0; rd_wr_n = 1'b1; addr = 4'd3; din = 4'hA; step();
        rd_wr_n = 1'b0; step();
        check("R4 write shows ~din", dout, 4'h5);
        din = 4'hC; step();
        check("R4 follows din", dout, 4'h3);
        check("R4 true variant follows din", dout_t, 4'hC);
        din = 4'h9; step();
        rd_wr_n = 1'b1; step();
        din = 4'h2; step();
        check("R5 later din ignored", dout, 4'h6);
        read_word(4'd3, v, t);
        check("R5 held value", t, 4'h9);
    endtask

    // R3: deselected write attempts change nothing and the bus floats.
    task automatic t_blocked();
        logic [3:0] v, t;
        write_word(4'd3, 4'hF);
        cs_n = 1'b1; step();
        rd_wr_n = 1'b0; din = 4'h0;
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a); step();
            check("R3 float during blocked write", dout, 4'b1111);
        end
        rd_wr_n = 1'b1; step();
        read_word(4'd3, v, t);
        check("R3 word 3 unchanged", v, 4'h0);
        read_word(4'd9, v, t);
        check("R3 word 9 unchanged", v, ~4'(9 ^ 5));
    endtask

    // R7: sweep with write held low clears everything.
    task automatic t_sweep_clear();
        logic [3:0] v, t;
        cs_n = 1'b0; rd_wr_n = 1'b1; din = 4'h0; addr = 4'd0; step();
        rd_wr_n = 1'b0;
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a); step();
        end
        rd_wr_n = 1'b1; step();
        for (int a = 0; a < 16; a++) begin
            read_word(4'(a), v, t);
            check("R7 cleared inverted", v, 4'hF);
            check("R7 cleared true", t, 4'h0);
        end
    endtask

    initial begin
        t_idle_float();
        t_fill_readback();
        t_transparent();
        t_blocked();
        t_sweep_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule